// File: doc/BRIEF.md
# Audio Port Control and Status Sequencer

This block holds the single control/status word of a PCM audio port. Its register bus runs on `bus_clk`, while the serializer and FIFOs it steers run on an unrelated PCM bit clock `pcm_clk`. Software writes one 32-bit word to set the port enable, the standby release, the transmit and receive run bits and the DMA request enable. The same write can request FIFO clears, toggle a handshake bit or acknowledge error flags. Reading returns the same word, with live status folded in.

Every control value crosses into the PCM domain through a two-flop synchronizer. The port becomes active only after the enable and the standby release have both been seen there for a fixed number of PCM clocks. A FIFO clear is a four-phase request/acknowledge handshake. The PCM side holds the clear strobe for a fixed number of PCM clocks, and the bit reads back as 1 until the handshake has fully returned. The handshake bit (bit 24) goes to the PCM domain and is echoed back, so software can confirm that the PCM clock is running: while that clock is stopped, the read-back value never changes.

The block has no streaming data interface, so no valid/ready rules apply. Every pin is a plain control or status level, or a single-cycle write strobe.

Top module: `pcm_ctl_seq`

## Requirements
- R1: A write with `csr_wr_en` high loads bit 0 (port enable), bit 1 (receive on), bit 2 (transmit on), bit 9 (DMA request enable) and bit 25 (standby release). These read back at the same positions from the next bus cycle, and `dma_req_en` follows bit 9.
- R2: `pcm_active` rises only after bits 0 and 25 have both been 1 at the output of the PCM-side synchronizer for 4 consecutive PCM clock edges (parameter STBY_CYCLES). It falls on the PCM edge after either bit is seen low there.
- R3: `pcm_tx_run` equals `pcm_active` AND the synchronized bit 2, and `pcm_rx_run` equals `pcm_active` AND the synchronized bit 1.
- R4: Writing 1 to bit 3 (transmit) or bit 4 (receive) starts a FIFO clear. The matching PCM strobe is high for exactly 2 PCM clock cycles (parameter CLR_CYCLES), and the bit reads 1 from the cycle after the write until the acknowledge has returned and been withdrawn.
- R5: A clear request written while the same clear is still busy is ignored and produces no second strobe.
- R6: Bit 24 reads back the last value written to it only after that value has passed two PCM clock edges and two bus clock edges. On the bus cycle after the write it still shows the old value.
- R7: While `pcm_clk` is stopped, bit 24 keeps its old read-back value for any number of bus cycles, whatever is written to it.
- R8: Bit 21 reads `pcm_tx_empty` and bit 20 reads `pcm_rx_avail`, each after a two-flop bus-domain synchronizer.
- R9: A one-cycle pulse on `pcm_tx_err_pulse` or `pcm_rx_err_pulse` sets sticky bit 15 or bit 16 respectively. Writing 1 to that bit clears it, but an error arriving in the same cycle wins and the bit stays set.
- R10: During reset, `csr_rdata` is zero and all PCM-side outputs and `dma_req_en` are low.
- R11: All bit positions not listed in R1 to R9 read as 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| csr_wr_en | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data: control bits and live status |
| dma_req_en | output | 1 | DMA request enable, bus domain |
| pcm_clk | input | 1 | PCM bit clock |
| pcm_rst_n | input | 1 | Active-low asynchronous reset, PCM domain |
| pcm_tx_empty | input | 1 | Transmit FIFO empty, PCM domain |
| pcm_rx_avail | input | 1 | Receive FIFO holds data, PCM domain |
| pcm_tx_err_pulse | input | 1 | One-cycle transmit error event, PCM domain |
| pcm_rx_err_pulse | input | 1 | One-cycle receive error event, PCM domain |
| pcm_active | output | 1 | Port enabled and out of standby |
| pcm_tx_run | output | 1 | Transmit serializer run |
| pcm_rx_run | output | 1 | Receive serializer run |
| pcm_tx_fifo_clr | output | 1 | Transmit FIFO clear strobe |
| pcm_rx_fifo_clr | output | 1 | Receive FIFO clear strobe |

## Verification
The bench drives two clocks whose edges never coincide. It checks the exact bus cycle and PCM cycle in which each crossing lands. A synchronizer that is one stage short or long would move a read-back or a strobe by a cycle and break the comparison.

The bench also goes after several specific corner cases:
- It stops the PCM clock and toggles the handshake bit. A design that echoed the bit from the bus side would read back the new value with no PCM clock running.
- It repeats clear requests while a clear is still busy. A design without the busy guard would emit a second strobe or leave the request stuck.
- It clears an error flag close to a new error event, where a clear-first priority would lose the event.
- It writes all ones, which shows whether any unused position leaks out.

// File: rtl/pcm_ctl_pkg.sv
package pcm_ctl_pkg;
  localparam int CSR_W    = 32;
  localparam int B_EN     = 0;
  localparam int B_RXON   = 1;
  localparam int B_TXON   = 2;
  localparam int B_TXCLR  = 3;
  localparam int B_RXCLR  = 4;
  localparam int B_DMA    = 9;
  localparam int B_TXERR  = 15;
  localparam int B_RXERR  = 16;
  localparam int B_RXAVL  = 20;
  localparam int B_TXEMP  = 21;
  localparam int B_SYNC   = 24;
  localparam int B_STBY   = 25;
  localparam int NUM_DIR  = 2;

  typedef struct packed {
    logic stby;
    logic txon;
    logic rxon;
    logic en;
  } pcm_ctl_t;
endpackage

// File: rtl/pcm_ctl_sync.sv
module pcm_ctl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1, st2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1 <= d;
      st2 <= st1;
    end
  end

  assign q = st2;
endmodule

// File: rtl/pcm_clr_hs.sv
module pcm_clr_hs #(
  parameter int CLR_CYCLES = 2
) (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic start_i,
  output logic busy_o,
  input  logic pcm_clk,
  input  logic pcm_rst_n,
  output logic clr_o
);
  localparam int CW = $clog2(CLR_CYCLES + 1);

  logic          req_q, ack_b, req_p, ack_p;
  logic [CW-1:0] hold_cnt;

  // bus side: request held until acknowledge seen, then dropped
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n)                        req_q <= 1'b0;
    else if (req_q && ack_b)               req_q <= 1'b0;
    else if (start_i && !req_q && !ack_b)  req_q <= 1'b1;
  end

  assign busy_o = req_q | ack_b;

  pcm_ctl_sync #(.W(1)) u_req_fwd (.clk(pcm_clk), .rst_n(pcm_rst_n), .d(req_q), .q(req_p));
  pcm_ctl_sync #(.W(1)) u_ack_back (.clk(bus_clk), .rst_n(bus_rst_n), .d(ack_p), .q(ack_b));

  // PCM side: strobe for CLR_CYCLES clocks, then acknowledge
  always_ff @(posedge pcm_clk or negedge pcm_rst_n) begin
    if (!pcm_rst_n) begin
      ack_p    <= 1'b0;
      hold_cnt <= '0;
    end else if (!req_p) begin
      ack_p    <= 1'b0;
      hold_cnt <= '0;
    end else if (!ack_p) begin
      if (hold_cnt == CW'(CLR_CYCLES - 1)) begin
        ack_p    <= 1'b1;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + CW'(1);
      end
    end
  end

  assign clr_o = req_p & ~ack_p;

  // R4
  req_drop_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $fell(req_q) |-> $past(ack_b));
  // R5
  busy_ignore_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (busy_o && start_i) |=> !$rose(req_q));
  // R4
  ack_after_clr_chk: assert property (@(posedge pcm_clk) disable iff (!pcm_rst_n)
    $rose(ack_p) |-> $past(clr_o));
endmodule

// File: rtl/pcm_run_ctl.sv
module pcm_run_ctl
  import pcm_ctl_pkg::*;
#(
  parameter int STBY_CYCLES = 4
) (
  input  logic     pcm_clk,
  input  logic     pcm_rst_n,
  input  pcm_ctl_t ctl_i,
  output logic     active_o,
  output logic     tx_run_o,
  output logic     rx_run_o
);
  localparam int SW = $clog2(STBY_CYCLES + 1);

  pcm_ctl_t      ctl_p;
  logic          rdy_q;
  logic [SW-1:0] wake_cnt;

  pcm_ctl_sync #(.W($bits(pcm_ctl_t))) u_ctl_sync (
    .clk(pcm_clk), .rst_n(pcm_rst_n), .d(ctl_i), .q(ctl_p)
  );

  always_ff @(posedge pcm_clk or negedge pcm_rst_n) begin
    if (!pcm_rst_n) begin
      rdy_q    <= 1'b0;
      wake_cnt <= '0;
    end else if (!(ctl_p.en && ctl_p.stby)) begin
      rdy_q    <= 1'b0;
      wake_cnt <= '0;
    end else if (!rdy_q) begin
      if (wake_cnt == SW'(STBY_CYCLES - 1)) rdy_q <= 1'b1;
      else                                  wake_cnt <= wake_cnt + SW'(1);
    end
  end

  assign active_o = rdy_q;
  assign tx_run_o = rdy_q & ctl_p.txon;
  assign rx_run_o = rdy_q & ctl_p.rxon;

  // R2
  ready_qual_chk: assert property (@(posedge pcm_clk) disable iff (!pcm_rst_n)
    $rose(rdy_q) |-> $past(ctl_p.en && ctl_p.stby));
endmodule

// File: rtl/pcm_err_flag.sv
module pcm_err_flag (
  input  logic pcm_clk,
  input  logic pcm_rst_n,
  input  logic pulse_i,
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic clr_i,
  output logic flag_o
);
  logic tog_p, tog_b, tog_seen, flag_q, evt;

  always_ff @(posedge pcm_clk or negedge pcm_rst_n) begin
    if (!pcm_rst_n)   tog_p <= 1'b0;
    else if (pulse_i) tog_p <= ~tog_p;
  end

  pcm_ctl_sync #(.W(1)) u_tog_sync (.clk(bus_clk), .rst_n(bus_rst_n), .d(tog_p), .q(tog_b));

  assign evt = tog_b ^ tog_seen;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      tog_seen <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      tog_seen <= tog_b;
      if (evt)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R9
  err_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/pcm_ctl_seq.sv
module pcm_ctl_seq
  import pcm_ctl_pkg::*;
#(
  parameter int CLR_CYCLES  = 2,
  parameter int STBY_CYCLES = 4
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             csr_wr_en,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             dma_req_en,
  input  logic             pcm_clk,
  input  logic             pcm_rst_n,
  input  logic             pcm_tx_empty,
  input  logic             pcm_rx_avail,
  input  logic             pcm_tx_err_pulse,
  input  logic             pcm_rx_err_pulse,
  output logic             pcm_active,
  output logic             pcm_tx_run,
  output logic             pcm_rx_run,
  output logic             pcm_tx_fifo_clr,
  output logic             pcm_rx_fifo_clr
);
  pcm_ctl_t ctl_q;
  logic     dma_q, sync_q, sync_p, sync_echo;
  logic [1:0] lvl_b;
  logic [NUM_DIR-1:0] clr_busy, clr_pcm, err_flag, err_pulse;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      ctl_q  <= '0;
      dma_q  <= 1'b0;
      sync_q <= 1'b0;
    end else if (csr_wr_en) begin
      ctl_q.en   <= csr_wdata[B_EN];
      ctl_q.rxon <= csr_wdata[B_RXON];
      ctl_q.txon <= csr_wdata[B_TXON];
      ctl_q.stby <= csr_wdata[B_STBY];
      dma_q      <= csr_wdata[B_DMA];
      sync_q     <= csr_wdata[B_SYNC];
    end
  end

  pcm_run_ctl #(.STBY_CYCLES(STBY_CYCLES)) u_run (
    .pcm_clk(pcm_clk), .pcm_rst_n(pcm_rst_n), .ctl_i(ctl_q),
    .active_o(pcm_active), .tx_run_o(pcm_tx_run), .rx_run_o(pcm_rx_run)
  );

  // handshake bit: out to the PCM domain and echoed back
  pcm_ctl_sync #(.W(1)) u_sync_fwd (.clk(pcm_clk), .rst_n(pcm_rst_n), .d(sync_q), .q(sync_p));
  pcm_ctl_sync #(.W(1)) u_sync_back (.clk(bus_clk), .rst_n(bus_rst_n), .d(sync_p), .q(sync_echo));

  pcm_ctl_sync #(.W(2)) u_lvl_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d({pcm_rx_avail, pcm_tx_empty}), .q(lvl_b)
  );

  assign err_pulse = {pcm_rx_err_pulse, pcm_tx_err_pulse};

  for (genvar k = 0; k < NUM_DIR; k++) begin : g_dir
    localparam int CB = (k == 0) ? B_TXCLR : B_RXCLR;
    localparam int EB = (k == 0) ? B_TXERR : B_RXERR;

    pcm_clr_hs #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
      .start_i(csr_wr_en & csr_wdata[CB]), .busy_o(clr_busy[k]),
      .pcm_clk(pcm_clk), .pcm_rst_n(pcm_rst_n), .clr_o(clr_pcm[k])
    );

    pcm_err_flag u_err (
      .pcm_clk(pcm_clk), .pcm_rst_n(pcm_rst_n), .pulse_i(err_pulse[k]),
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
      .clr_i(csr_wr_en & csr_wdata[EB]), .flag_o(err_flag[k])
    );
  end

  assign pcm_tx_fifo_clr = clr_pcm[0];
  assign pcm_rx_fifo_clr = clr_pcm[1];
  assign dma_req_en      = dma_q;

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[B_EN]    = ctl_q.en;
    csr_rdata[B_RXON]  = ctl_q.rxon;
    csr_rdata[B_TXON]  = ctl_q.txon;
    csr_rdata[B_TXCLR] = clr_busy[0];
    csr_rdata[B_RXCLR] = clr_busy[1];
    csr_rdata[B_DMA]   = dma_q;
    csr_rdata[B_TXERR] = err_flag[0];
    csr_rdata[B_RXERR] = err_flag[1];
    csr_rdata[B_RXAVL] = lvl_b[1];
    csr_rdata[B_TXEMP] = lvl_b[0];
    csr_rdata[B_SYNC]  = sync_echo;
    csr_rdata[B_STBY]  = ctl_q.stby;
  end
endmodule

// File: tb/pcm_ctl_seq_bench.sv
module pcm_ctl_seq_bench;
  localparam int BUS_PERIOD = 10;
  localparam int PCM_PERIOD = 36;
  localparam int STBY_N = 4;
  localparam int CLR_N  = 2;
  localparam logic [31:0] USED_MASK = 32'h0331_821F;
  localparam logic [31:0] RUN_WORD  = 32'h0200_0207;

  logic bus_clk = 1'b0, pcm_clk = 1'b0, pcm_go = 1'b1, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic tx_empty = 1'b0, rx_avail = 1'b0, tx_err = 1'b0, rx_err = 1'b0;
  logic [31:0] rdata;
  logic dma_en, act, txrun, rxrun, txclr, rxclr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always begin
    #(PCM_PERIOD/2);
    if (pcm_go) pcm_clk = ~pcm_clk;
  end

  pcm_ctl_seq u_pcm_ctl_seq (
    .bus_clk(bus_clk), .bus_rst_n(rst_n), .csr_wr_en(wr_en), .csr_wdata(wdata),
    .csr_rdata(rdata), .dma_req_en(dma_en), .pcm_clk(pcm_clk), .pcm_rst_n(rst_n),
    .pcm_tx_empty(tx_empty), .pcm_rx_avail(rx_avail),
    .pcm_tx_err_pulse(tx_err), .pcm_rx_err_pulse(rx_err),
    .pcm_active(act), .pcm_tx_run(txrun), .pcm_rx_run(rxrun),
    .pcm_tx_fifo_clr(txclr), .pcm_rx_fifo_clr(rxclr)
  );

  // ---------------- reference model ----------------
  // bus view: control bits, clear requests, sticky errors
  logic m_en, m_rx, m_tx, m_dma, m_stby, m_sync;
  logic m_req [2];
  logic m_err [2];
  // samples of PCM-side state taken at bus edges: {rxav,txemp,sync,tog1,tog0,ack1,ack0}
  logic [6:0] bq[$];
  // samples of bus-side state taken at PCM edges: {sync,req1,req0,rx,tx,stby,en}
  logic [6:0] pq[$];
  int   p_streak;
  logic p_ack [2];
  int   p_cnt [2];
  logic p_tog [2];

  always @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_en, m_rx, m_tx, m_dma, m_stby, m_sync} = '0;
      for (int c = 0; c < 2; c++) begin m_req[c] = 0; m_err[c] = 0; end
      bq = '{7'd0, 7'd0, 7'd0, 7'd0};
    end else begin
      bq.push_front({rx_avail, tx_empty, pq[1][6], p_tog[1], p_tog[0], p_ack[1], p_ack[0]});
      void'(bq.pop_back());
      for (int c = 0; c < 2; c++) begin
        logic ack_old, ev;
        ack_old = bq[2][c];
        if (m_req[c] && ack_old) m_req[c] = 0;
        else if (wr_en && wdata[3 + c] && !m_req[c] && !ack_old) m_req[c] = 1;
        ev = bq[2][2 + c] ^ bq[3][2 + c];
        if (ev) m_err[c] = 1;
        else if (wr_en && wdata[15 + c]) m_err[c] = 0;
      end
      if (wr_en) begin
        m_en = wdata[0]; m_rx = wdata[1]; m_tx = wdata[2];
        m_dma = wdata[9]; m_sync = wdata[24]; m_stby = wdata[25];
      end
    end
  end

  always @(posedge pcm_clk or negedge rst_n) begin
    if (!rst_n) begin
      pq = '{7'd0, 7'd0, 7'd0};
      p_streak = 0;
      for (int c = 0; c < 2; c++) begin p_ack[c] = 0; p_cnt[c] = 0; p_tog[c] = 0; end
    end else begin
      logic [6:0] old;
      pq.push_front({m_sync, m_req[1], m_req[0], m_rx, m_tx, m_stby, m_en});
      void'(pq.pop_back());
      old = pq[2];
      if (old[0] && old[1]) begin if (p_streak < 1000) p_streak++; end
      else p_streak = 0;
      for (int c = 0; c < 2; c++) begin
        if (!old[4 + c]) begin p_ack[c] = 0; p_cnt[c] = 0; end
        else if (!p_ack[c]) begin
          if (p_cnt[c] == CLR_N - 1) begin p_ack[c] = 1; p_cnt[c] = 0; end
          else p_cnt[c]++;
        end
      end
      if (tx_err) p_tog[0] = ~p_tog[0];
      if (rx_err) p_tog[1] = ~p_tog[1];
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] e;
    e = '0;
    e[0] = m_en; e[1] = m_rx; e[2] = m_tx;
    e[3] = m_req[0] | bq[1][0];
    e[4] = m_req[1] | bq[1][1];
    e[9] = m_dma; e[15] = m_err[0]; e[16] = m_err[1];
    e[20] = bq[1][6]; e[21] = bq[1][5]; e[24] = bq[1][4]; e[25] = m_stby;
    return e;
  endfunction

  function automatic string rd_tag(logic [31:0] d);
    if (d[24])                      return pcm_go ? "R6" : "R7";
    if (d[3] | d[4])                return "R4";
    if (d[15] | d[16])              return "R9";
    if (d[20] | d[21])              return "R8";
    if (|(d & 32'h0200_0207))       return "R1";
    return "R11";
  endfunction

  // ---------------- per-cycle comparison ----------------
  always @(negedge bus_clk) begin
    if (rst_n && !done) begin
      logic [31:0] e;
      e = exp_rd();
      n_chk++;
      if (rdata !== e || dma_en !== m_dma) begin
        n_fail++;
        $display("FAIL %s bus t=%0t rdata=%h dma=%b expected rdata=%h dma=%b",
                 rd_tag(rdata ^ e), $time, rdata, dma_en, e, m_dma);
      end
    end
  end

  always @(negedge pcm_clk) begin
    if (rst_n && !done) begin
      logic e_act, e_tr, e_rr, e_tc, e_rc;
      e_act = (p_streak >= STBY_N);
      e_tr = e_act & pq[1][2];
      e_rr = e_act & pq[1][3];
      e_tc = pq[1][4] & ~p_ack[0];
      e_rc = pq[1][5] & ~p_ack[1];
      n_chk++;
      if ({act, txrun, rxrun, txclr, rxclr} !== {e_act, e_tr, e_rr, e_tc, e_rc}) begin
        n_fail++;
        $display("FAIL %s pcm t=%0t act/tx/rx/tclr/rclr=%b expected %b",
                 (act !== e_act) ? "R2" : ((txrun !== e_tr || rxrun !== e_rr) ? "R3" : "R4"),
                 $time, {act, txrun, rxrun, txclr, rxclr}, {e_act, e_tr, e_rr, e_tc, e_rc});
      end
    end
  end

  // strobe counters for directed clear checks
  int tx_rises = 0, tx_highs = 0;
  logic tx_prev = 1'b0;
  always @(negedge pcm_clk) begin
    if (txclr && !tx_prev) tx_rises++;
    if (txclr) tx_highs++;
    tx_prev = txclr;
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s directed t=%0t actual=%h expected=%h", tag, $time, got, want);
    end
  endtask

  task automatic bus_wr(input logic [31:0] d);
    @(negedge bus_clk); wr_en = 1'b1; wdata = d;
    @(negedge bus_clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(BUS_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int r0, h0;
    bus_idle(5);
    // R10 reset state
    check("R10", rdata, 32'h0);
    check("R10", {26'd0, dma_en, act, txrun, rxrun, txclr, rxclr}, 32'h0);
    bus_idle(3);
    rst_n = 1'b1;

    // R1 / R2 : enable + standby release
    bus_wr(32'h0200_0001);
    check("R1", rdata & 32'h0200_0207, 32'h0200_0001);
    bus_idle(40);
    check("R2", {31'd0, act}, 32'd1);

    // R3 : run bits
    bus_wr(RUN_WORD);
    bus_idle(30);
    check("R3", {29'd0, txrun, rxrun, dma_en}, 32'd7);

    // R4 : transmit clear, strobe exactly CLR_N PCM cycles
    r0 = tx_rises; h0 = tx_highs;
    bus_wr(RUN_WORD | 32'h8);
    check("R4", {31'd0, rdata[3]}, 32'd1);
    bus_idle(60);
    check("R4", tx_rises - r0, 1);
    check("R4", tx_highs - h0, CLR_N);
    check("R4", {31'd0, rdata[3]}, 32'd0);

    // R5 : repeated requests while busy
    r0 = tx_rises;
    bus_wr(RUN_WORD | 32'h8);
    bus_wr(RUN_WORD | 32'h8);
    bus_wr(RUN_WORD | 32'h8);
    bus_idle(60);
    check("R5", tx_rises - r0, 1);

    // receive clear
    bus_wr(RUN_WORD | 32'h10);
    bus_idle(60);

    // R6 : handshake bit delayed through both domains
    bus_wr(RUN_WORD | 32'h0100_0000);
    check("R6", {31'd0, rdata[24]}, 32'd0);
    bus_idle(40);
    check("R6", {31'd0, rdata[24]}, 32'd1);

    // R8 : status levels
    @(negedge pcm_clk); tx_empty = 1'b1; rx_avail = 1'b1;
    bus_idle(5);
    check("R8", {30'd0, rdata[21], rdata[20]}, 32'd3);
    @(negedge pcm_clk); rx_avail = 1'b0;
    bus_idle(5);
    check("R8", {30'd0, rdata[21], rdata[20]}, 32'd2);

    // R9 : sticky errors, write-one-to-clear
    @(negedge pcm_clk); tx_err = 1'b1;
    @(negedge pcm_clk); tx_err = 1'b0;
    bus_idle(10);
    check("R9", {31'd0, rdata[15]}, 32'd1);
    bus_idle(10);
    check("R9", {31'd0, rdata[15]}, 32'd1);
    bus_wr(RUN_WORD | 32'h0100_8000);
    check("R9", {31'd0, rdata[15]}, 32'd0);
    // clear near a new event: model decides priority
    @(negedge pcm_clk); rx_err = 1'b1;
    @(negedge pcm_clk); rx_err = 1'b0;
    for (int i = 0; i < 6; i++) bus_wr(RUN_WORD | 32'h0101_0000);
    @(negedge pcm_clk); rx_err = 1'b1;
    @(negedge pcm_clk); rx_err = 1'b0;
    bus_idle(10);
    check("R9", {31'd0, rdata[16]}, 32'd1);

    // R11 : unused positions stay zero
    bus_wr(32'hFFFF_FFFF);
    bus_idle(2);
    check("R11", rdata & ~USED_MASK, 32'h0);
    bus_idle(60);
    check("R6", {31'd0, rdata[24]}, 32'd1);

    // R7 : PCM clock stopped, handshake bit frozen
    @(negedge pcm_clk); pcm_go = 1'b0;
    bus_wr(RUN_WORD);
    bus_idle(40);
    check("R7", {31'd0, rdata[24]}, 32'd1);
    bus_idle(40);
    check("R7", {31'd0, rdata[24]}, 32'd1);
    pcm_go = 1'b1;
    bus_idle(40);
    check("R7", {31'd0, rdata[24]}, 32'd0);

    // R2 : disable drops the port
    bus_wr(32'h0000_0000);
    bus_idle(30);
    check("R2", {29'd0, act, txrun, rxrun}, 32'd0);
    finish_run();
  end
endmodule